// File: doc/BRIEF.md
# Control-Flow Resolution Unit

This combinational unit works out where the program counter goes next for a control-flow micro-op, and whether the instruction writes a return address. It takes a two-bit class and a three-bit subfunction code, a flag that marks a compressed (16-bit) instruction, and a flag that selects a register-based jump. It also takes the current PC, two register operands, a precomputed PC-relative target, the trap vector and the exception return address.

For conditional branches it compares the two register operands. A taken branch goes to the precomputed target. A branch that is not taken falls through by the instruction length. Jumps go either to the precomputed target or to the sum of the register operands with bit 0 cleared. The linking form of the jump also produces a return address. Traps go to the trap vector and trap return goes to the exception return address. Every code that is not listed here resolves as a plain fall-through.

Top module: `ctl_flow_resolve`

## Requirements
- R1: With class 00 the branch is taken when its condition holds on opA and opB: sub 001 equal, 010 signed opA >= opB, 011 unsigned opA >= opB, 100 signed opA < opB, 101 unsigned opA < opB, 110 not equal.
- R2: A taken branch sets nextPc to opC and raises redirect. It never raises linkWe.
- R3: A branch that is not taken sets nextPc to pc+4, or to pc+2 when isCompressed is 1. Both redirect and linkWe stay 0.
- R4: Class 01 sub 000 (trap entry) sets nextPc to trapVec and raises redirect, with linkWe at 0.
- R5: Class 10 sub 000 is a jump without link, with redirect 1 and linkWe 0. When isRegJump is 0 the target is opC. When isRegJump is 1 the target is opA+opB.
- R6: Class 10 sub 001 jumps to the same target as R5, raises linkWe, and sets linkVal to pc+4, or to pc+2 when isCompressed is 1.
- R7: Class 11 sub 000 (trap return) sets nextPc to retAddr and raises redirect, with linkWe at 0.
- R8: A register-based jump target always has bit 0 forced to 0. The other bits are the sum.
- R9: Every other class/sub code gives nextPc equal to the fall-through address of R3, with redirect 0 and linkWe 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| uopClass | input | 2 | Micro-op class |
| uopSub | input | 3 | Micro-op subfunction |
| isCompressed | input | 1 | Instruction is 16 bits long |
| isRegJump | input | 1 | Jump target comes from the register operands |
| pc | input | XLEN | Current program counter |
| opA | input | XLEN | Register operand A |
| opB | input | XLEN | Register operand B or immediate |
| opC | input | XLEN | Precomputed PC-relative target |
| trapVec | input | XLEN | Trap vector address |
| retAddr | input | XLEN | Exception return address |
| nextPc | output | XLEN | Resolved next program counter |
| redirect | output | 1 | Control flow leaves the sequential path |
| linkWe | output | 1 | Write the link value to the destination register |
| linkVal | output | XLEN | Return address (pc plus instruction length) |

## Verification
The fall-through adder has two users in the same evaluation. It supplies the not-taken target, and it supplies the link value of a linking jump. Both depend on isCompressed. The bench sweeps every class/sub code against both instruction lengths, both jump kinds and a set of operand pairs. The pairs cover equality, sign-bit disagreement and odd register sums. For each case it judges nextPc, redirect, linkWe and, when linkWe is set, linkVal against values it computes itself.

// File: rtl/cfr_pkg.sv
package cfr_pkg;
  typedef enum logic [2:0] {
    PC_FALL = 3'd0,
    PC_OPC  = 3'd1,
    PC_REG  = 3'd2,
    PC_TVEC = 3'd3,
    PC_EPC  = 3'd4
  } pcSel_e;

  typedef struct packed {
    pcSel_e pcSel;
    logic   redirect;
    logic   linkWe;
  } ctrl_t;

  localparam logic [1:0] CLS_BRANCH = 2'b00;
  localparam logic [1:0] CLS_TRAP   = 2'b01;
  localparam logic [1:0] CLS_JUMP   = 2'b10;
  localparam logic [1:0] CLS_RET    = 2'b11;
endpackage

// File: rtl/cfr_ctrl.sv
module cfr_ctrl
  import cfr_pkg::*;
(
  input  logic [1:0] uopClass,
  input  logic [2:0] uopSub,
  input  logic       isRegJump,
  input  logic       cmpEq,
  input  logic       cmpLt,
  input  logic       cmpLtu,
  output ctrl_t      ctrl
);
  logic condMet;

  always_comb begin
    unique case (uopSub)
      3'b001:  condMet = cmpEq;
      3'b010:  condMet = !cmpLt;
      3'b011:  condMet = !cmpLtu;
      3'b100:  condMet = cmpLt;
      3'b101:  condMet = cmpLtu;
      3'b110:  condMet = !cmpEq;
      default: condMet = 1'b0;
    endcase
  end

  always_comb begin
    ctrl.pcSel    = PC_FALL;
    ctrl.redirect = 1'b0;
    ctrl.linkWe   = 1'b0;
    unique case (uopClass)
      CLS_BRANCH: if (condMet) begin
        ctrl.pcSel    = PC_OPC;
        ctrl.redirect = 1'b1;
      end
      CLS_TRAP: if (uopSub == 3'b000) begin
        ctrl.pcSel    = PC_TVEC;
        ctrl.redirect = 1'b1;
      end
      CLS_JUMP: if (uopSub == 3'b000 || uopSub == 3'b001) begin
        ctrl.pcSel    = isRegJump ? PC_REG : PC_OPC;
        ctrl.redirect = 1'b1;
        ctrl.linkWe   = uopSub[0];
      end
      default: if (uopSub == 3'b000) begin
        ctrl.pcSel    = PC_EPC;
        ctrl.redirect = 1'b1;
      end
    endcase
  end

  always_comb begin
    // R3
    notaken_quiet_chk: assert (ctrl.redirect || (ctrl.pcSel == PC_FALL && !ctrl.linkWe))
      else $error("not-taken result selects a target or writes link");
  end
endmodule

// File: rtl/cfr_datapath.sv
module cfr_datapath
  import cfr_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] pc,
  input  logic [XLEN-1:0] opA,
  input  logic [XLEN-1:0] opB,
  input  logic [XLEN-1:0] opC,
  input  logic [XLEN-1:0] trapVec,
  input  logic [XLEN-1:0] retAddr,
  input  logic            isCompressed,
  input  ctrl_t           ctrl,
  output logic            cmpEq,
  output logic            cmpLt,
  output logic            cmpLtu,
  output logic [XLEN-1:0] nextPc,
  output logic [XLEN-1:0] linkVal
);
  localparam logic [XLEN-1:0] STEP_FULL = XLEN'(4);
  localparam logic [XLEN-1:0] STEP_HALF = XLEN'(2);
  localparam logic [XLEN-1:0] ALIGN_MASK = {{(XLEN-1){1'b1}}, 1'b0};

  logic [XLEN-1:0] fallPc;
  logic [XLEN-1:0] regSum;
  logic [XLEN-1:0] regTarget;

  assign cmpEq  = (opA == opB);
  assign cmpLt  = ($signed(opA) < $signed(opB));
  assign cmpLtu = (opA < opB);

  assign fallPc    = pc + (isCompressed ? STEP_HALF : STEP_FULL);
  assign regSum    = opA + opB;
  assign regTarget = regSum & ALIGN_MASK;
  assign linkVal   = fallPc;

  always_comb begin
    unique case (ctrl.pcSel)
      PC_OPC:  nextPc = opC;
      PC_REG:  nextPc = regTarget;
      PC_TVEC: nextPc = trapVec;
      PC_EPC:  nextPc = retAddr;
      default: nextPc = fallPc;
    endcase
  end

  always_comb begin
    // R8
    reg_target_aligned_chk: assert (ctrl.pcSel != PC_REG || nextPc[0] == 1'b0)
      else $error("register jump target has bit 0 set");
    // R3
    fallthrough_step_chk: assert (ctrl.pcSel != PC_FALL ||
                                  nextPc - pc == (isCompressed ? STEP_HALF : STEP_FULL))
      else $error("fall-through step does not match instruction length");
  end
endmodule

// File: rtl/ctl_flow_resolve.sv
module ctl_flow_resolve
  import cfr_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [1:0]      uopClass,
  input  logic [2:0]      uopSub,
  input  logic            isCompressed,
  input  logic            isRegJump,
  input  logic [XLEN-1:0] pc,
  input  logic [XLEN-1:0] opA,
  input  logic [XLEN-1:0] opB,
  input  logic [XLEN-1:0] opC,
  input  logic [XLEN-1:0] trapVec,
  input  logic [XLEN-1:0] retAddr,
  output logic [XLEN-1:0] nextPc,
  output logic            redirect,
  output logic            linkWe,
  output logic [XLEN-1:0] linkVal
);
  ctrl_t ctrl;
  logic  cmpEq, cmpLt, cmpLtu;

  cfr_ctrl u_ctrl (
    .uopClass (uopClass),
    .uopSub   (uopSub),
    .isRegJump(isRegJump),
    .cmpEq    (cmpEq),
    .cmpLt    (cmpLt),
    .cmpLtu   (cmpLtu),
    .ctrl     (ctrl)
  );

  cfr_datapath #(.XLEN(XLEN)) u_dp (
    .pc          (pc),
    .opA         (opA),
    .opB         (opB),
    .opC         (opC),
    .trapVec     (trapVec),
    .retAddr     (retAddr),
    .isCompressed(isCompressed),
    .ctrl        (ctrl),
    .cmpEq       (cmpEq),
    .cmpLt       (cmpLt),
    .cmpLtu      (cmpLtu),
    .nextPc      (nextPc),
    .linkVal     (linkVal)
  );

  assign redirect = ctrl.redirect;
  assign linkWe   = ctrl.linkWe;

  always_comb begin
    // R6
    link_only_on_jump_chk: assert (!linkWe || (redirect && uopClass == CLS_JUMP))
      else $error("link write outside a linking jump");
    // R2
    branch_target_chk: assert (!(uopClass == CLS_BRANCH && redirect) || nextPc == opC)
      else $error("taken branch did not go to opC");
    // R7
    return_target_chk: assert (!(uopClass == CLS_RET && uopSub == 3'b000) || nextPc == retAddr)
      else $error("trap return did not go to retAddr");
  end
endmodule

// File: tb/ctl_flow_resolve_tb.sv
module ctl_flow_resolve_tb;
  localparam int XLEN = 32;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [1:0]      uopClass;
  logic [2:0]      uopSub;
  logic            isCompressed, isRegJump;
  logic [XLEN-1:0] pc, opA, opB, opC, trapVec, retAddr;
  logic [XLEN-1:0] nextPc, linkVal;
  logic            redirect, linkWe;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  ctl_flow_resolve #(.XLEN(XLEN)) u_dut (
    .uopClass(uopClass), .uopSub(uopSub), .isCompressed(isCompressed),
    .isRegJump(isRegJump), .pc(pc), .opA(opA), .opB(opB), .opC(opC),
    .trapVec(trapVec), .retAddr(retAddr), .nextPc(nextPc), .redirect(redirect),
    .linkWe(linkWe), .linkVal(linkVal)
  );

  task automatic check(input string tag, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h cls=%b sub=%b c=%b rj=%b A=%h B=%h",
               tag, act, exp, uopClass, uopSub, isCompressed, isRegJump, opA, opB);
    end
  endtask

  function automatic void pattern(input int i, output logic [XLEN-1:0] a, output logic [XLEN-1:0] b);
    case (i)
      0: begin a = 32'd5;          b = 32'd5;          end
      1: begin a = 32'd3;          b = 32'd7;          end
      2: begin a = 32'd7;          b = 32'd3;          end
      3: begin a = 32'h8000_0000;  b = 32'd1;          end
      4: begin a = 32'd1;          b = 32'h8000_0000;  end
      5: begin a = 32'hFFFF_FFFF;  b = 32'hFFFF_FFFF;  end
      6: begin a = 32'hFFFF_FFFF;  b = 32'd0;          end
      default: begin a = 32'h0000_1235; b = 32'h0000_0010; end
    endcase
  endfunction

  initial begin
    trapVec = 32'h0000_0100;
    retAddr = 32'h0000_2468;
    uopClass = '0; uopSub = '0; isCompressed = 0; isRegJump = 0;
    pc = '0; opA = '0; opB = '0; opC = '0;
    @(posedge clk);
    for (int cls = 0; cls < 4; cls++)
      for (int sub = 0; sub < 8; sub++)
        for (int cz = 0; cz < 2; cz++)
          for (int rj = 0; rj < 2; rj++)
            for (int p = 0; p < 8; p++) begin
              logic [XLEN-1:0] a, b, fall, expPc;
              logic expRed, expLink, cond;
              string tag;
              pattern(p, a, b);
              @(posedge clk);
              uopClass = cls[1:0]; uopSub = sub[2:0];
              isCompressed = cz[0]; isRegJump = rj[0];
              pc = 32'h0000_4000 + 32'(p * 64 + sub * 8);
              opA = a; opB = b;
              opC = 32'h1000_0AB0 + 32'(p * 16 + cls);
              fall = pc + (cz[0] ? 32'd2 : 32'd4);
              case (sub)
                1: cond = (a == b);
                2: cond = ($signed(a) >= $signed(b));
                3: cond = (a >= b);
                4: cond = ($signed(a) < $signed(b));
                5: cond = (a < b);
                6: cond = (a != b);
                default: cond = 1'b0;
              endcase
              expPc = fall; expRed = 0; expLink = 0; tag = "R9";
              if (cls == 0) begin
                tag = cond ? "R1/R2" : "R1/R3";
                if (cond) begin expPc = opC; expRed = 1; end
              end else if (cls == 1 && sub == 0) begin
                tag = "R4"; expPc = trapVec; expRed = 1;
              end else if (cls == 2 && sub < 2) begin
                tag = (sub == 1) ? "R6" : "R5";
                if (rj != 0) tag = {tag, "/R8"};
                expPc = (rj != 0) ? ((a + b) & ~32'd1) : opC;
                expRed = 1; expLink = (sub == 1);
              end else if (cls == 3 && sub == 0) begin
                tag = "R7"; expPc = retAddr; expRed = 1;
              end
              @(negedge clk);
              check({tag, " nextPc"}, nextPc, expPc);
              check({tag, " redirect"}, 32'(redirect), 32'(expRed));
              check({tag, " linkWe"}, 32'(linkWe), 32'(expLink));
              if (expLink) check("R6 linkVal", linkVal, fall);
            end
    done = 1'b1;
  end

  initial begin
    for (int t = 0; t < 100000; t++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule